// File: doc/BRIEF.md
# Single-Channel Descriptor DMA Engine

This block moves a block of items for one DMA channel. A descriptor comes in from an external fetcher. It holds an end pointer for the source, an end pointer for the destination and a 32-bit control word. The engine then performs one read and one write on a simple request/acknowledge memory bus for each item. Addresses are worked out backwards from the end pointers, so the last item of the block sits exactly at each end pointer.

The cycle type in the control word sets how requests are used:
- **Basic and ping-pong:** the engine needs its request line to stay asserted to get past each arbitration boundary.
- **Auto:** one trigger is enough to carry the whole block through to the end.

After every 2^R items the engine parks for at least one cycle so that an outside arbiter can step in. When a block finishes, the engine pulses a done flag and presents a control word to write back, in which the count and the cycle type are cleared. In ping-pong mode it also flips which descriptor (primary or alternate) is used next. A descriptor whose cycle type is stop or one of the unsupported gather codes raises an error pulse and makes no bus access.

Top module: `dma_chan_engine`

## Requirements
- R1: While reset is held, and right after it, `mem_req_o`, `done_o`, `err_o`, `wb_valid_o`, `arb_point_o` and `alt_sel_o` are all low.
- R2: A descriptor is taken in only when the engine is idle and `chan_en_i`, `req_i` and `desc_valid_i` are all high. `desc_ready_o` is high in exactly that case. With `chan_en_i` low, nothing is taken in and no bus access happens.
- R3: Control word fields:
  - destination increment: bits 31:30
  - destination size: bits 29:28
  - source increment: bits 27:26
  - source size: bits 25:24
  - arbitration power R: bits 17:14
  - count minus one: bits 13:4
  - cycle type: bits 2:0

  Bits 23:18 and bit 3 are carried through untouched.
- R4: A block has N = count + 1 items, from 1 to 1024. For each item the engine reads the source and then writes the destination, in item order. Item i (counting from 0) is at the end pointer minus (N-1-i) shifted left by the increment code. The increment codes are 00 for 1 byte, 01 for 2 bytes and 10 for 4 bytes.
- R5: An increment code of 11 leaves that side's address fixed at its end pointer for every item.
- R6: Size codes are 00 for byte, 01 for halfword, and 10 or 11 for word.
  - Reads take the item from the byte lane picked by address bits 1:0 (byte), or from the halfword lane picked by address bit 1 (halfword).
  - Writes repeat the item across all lanes.
  - Byte strobe on writes: `0001<<addr[1:0]` for a byte, `0011` or `1100` (chosen by addr[1]) for a halfword, `1111` for a word.
- R7: After each group of 2^R items that does not end the block, the engine parks. While parked, `arb_point_o` is high and no bus request is made. An R code of 10 or higher means 1024.
- R8: Auto mode (cycle type 010) leaves a park point after one cycle, whatever `req_i` is doing.
- R9: Basic mode (001) and ping-pong mode (011) stay parked until `req_i` is high.
- R10: When a block completes, `done_o` and `wb_valid_o` are high for exactly one cycle. `wb_ctrl_o` is then the control word with bits 13:4 and 2:0 cleared, and `wb_alt_o` names the descriptor that finished.
- R11: A completed ping-pong block flips `alt_sel_o`. Basic and auto blocks leave it as it is.
- R12: Cycle type 000 or 1xx gives a one-cycle `err_o` pulse. It causes no bus request, no done and no write-back.
- R13: Once raised, `mem_req_o` stays high until `mem_ack_i`, with `mem_addr_o` and `mem_we_o` held steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en_i | input | 1 | Channel enable |
| req_i | input | 1 | Channel request / trigger |
| desc_valid_i | input | 1 | Descriptor present |
| desc_ready_o | output | 1 | Descriptor taken this cycle |
| desc_src_end_i | input | ADDR_W | Source end pointer |
| desc_dst_end_i | input | ADDR_W | Destination end pointer |
| desc_ctrl_i | input | 32 | Control word |
| alt_sel_o | output | 1 | 0 primary, 1 alternate descriptor to use next |
| mem_req_o | output | 1 | Bus request |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | ADDR_W | Byte address |
| mem_be_o | output | 4 | Byte strobes |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Bus acknowledge |
| arb_point_o | output | 1 | Parked at an arbitration boundary |
| done_o | output | 1 | Block completion pulse |
| err_o | output | 1 | Invalid descriptor pulse |
| wb_valid_o | output | 1 | Write-back word valid |
| wb_ctrl_o | output | 32 | Control word to write back |
| wb_alt_o | output | 1 | Descriptor the write-back belongs to |

## Verification
The properties assume four things:
- The bus eventually answers every request.
- `mem_rdata_i` is valid in the same cycle as `mem_ack_i`.
- The descriptor inputs stay stable while `desc_valid_i` is high.
- Nothing else drives `req_i` into a request that the properties would read as part of a running block.

The stimulus follows these rules. It changes inputs only on the falling edge. It drops `desc_valid_i` in the cycle after acceptance. It keeps every generated address inside a 1 KiB modelled memory. It holds acknowledge low only in one directed stall window, during which the properties on the request must stay true.

// File: rtl/dmaeng_pkg.sv
package dmaeng_pkg;

    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;
    localparam int CNT_W  = 10;
    localparam int RP_W   = 4;

    localparam logic [2:0] CY_STOP  = 3'b000;
    localparam logic [2:0] CY_BASIC = 3'b001;
    localparam logic [2:0] CY_AUTO  = 3'b010;
    localparam logic [2:0] CY_PP    = 3'b011;

    // Control word; field order matches the bit layout (MSB first).
    typedef struct packed {
        logic [1:0]       dinc;
        logic [1:0]       dsz;
        logic [1:0]       sinc;
        logic [1:0]       ssz;
        logic [2:0]       dprot;
        logic [2:0]       sprot;
        logic [RP_W-1:0]  rpow;
        logic [CNT_W-1:0] nm1;
        logic             burst;
        logic [2:0]       cyc;
    } ctl_word_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RD    = 3'd1,
        ST_WR    = 3'd2,
        ST_PARK  = 3'd3,
        ST_FIN   = 3'd4,
        ST_FAULT = 3'd5
    } eng_st_e;

    function automatic logic mode_runs(input logic [2:0] c);
        return (c == CY_BASIC) || (c == CY_AUTO) || (c == CY_PP);
    endfunction

endpackage

// File: rtl/dmaeng_ctl_dec.sv
module dmaeng_ctl_dec
    import dmaeng_pkg::*;
(
    input  logic [RP_W-1:0]  rpow_i,
    input  logic [2:0]       cyc_i,
    output logic             self_req_o,
    output logic             swap_o,
    output logic [CNT_W-1:0] span_m1_o
);
    // Items per arbitration group minus one: bits below R set; R >= CNT_W saturates.
    always_comb begin
        for (int b = 0; b < CNT_W; b++) begin
            span_m1_o[b] = (b < int'(rpow_i));
        end
    end

    assign self_req_o = (cyc_i == CY_AUTO);
    assign swap_o     = (cyc_i == CY_PP);

endmodule

// File: rtl/dmaeng_agen.sv
module dmaeng_agen #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 10
) (
    input  logic [ADDR_W-1:0] end_ptr_i,
    input  logic [CNT_W-1:0]  remain_i,
    input  logic [1:0]        inc_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] back_off;

    always_comb begin
        back_off = ADDR_W'(remain_i) << inc_i;
        if (inc_i == 2'b11) begin
            addr_o = end_ptr_i;
        end else begin
            addr_o = end_ptr_i - back_off;
        end
    end

endmodule

// File: rtl/dmaeng_lane.sv
module dmaeng_lane
    import dmaeng_pkg::*;
(
    input  logic [1:0]        rd_lo_i,
    input  logic [1:0]        rd_sz_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [DATA_W-1:0] rd_item_o,
    output logic [BE_W-1:0]   rd_be_o,
    input  logic [1:0]        wr_lo_i,
    input  logic [1:0]        wr_sz_i,
    input  logic [DATA_W-1:0] item_i,
    output logic [DATA_W-1:0] wdata_o,
    output logic [BE_W-1:0]   wr_be_o
);
    function automatic logic [BE_W-1:0] strobe(input logic [1:0] lo, input logic [1:0] sz);
        case (sz)
            2'b00:   return BE_W'(1) << lo;
            2'b01:   return lo[1] ? 4'b1100 : 4'b0011;
            default: return '1;
        endcase
    endfunction

    always_comb begin
        case (rd_sz_i)
            2'b00:   rd_item_o = DATA_W'(rdata_i[{rd_lo_i, 3'b000} +: 8]);
            2'b01:   rd_item_o = DATA_W'(rdata_i[{rd_lo_i[1], 4'b0000} +: 16]);
            default: rd_item_o = rdata_i;
        endcase
        case (wr_sz_i)
            2'b00:   wdata_o = {BE_W{item_i[7:0]}};
            2'b01:   wdata_o = {(BE_W/2){item_i[15:0]}};
            default: wdata_o = item_i;
        endcase
        rd_be_o = strobe(rd_lo_i, rd_sz_i);
        wr_be_o = strobe(wr_lo_i, wr_sz_i);
    end

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
    import dmaeng_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en_i,
    input  logic              req_i,
    input  logic              desc_valid_i,
    output logic              desc_ready_o,
    input  logic [ADDR_W-1:0] desc_src_end_i,
    input  logic [ADDR_W-1:0] desc_dst_end_i,
    input  logic [31:0]       desc_ctrl_i,
    output logic              alt_sel_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [3:0]        mem_be_o,
    output logic [31:0]       mem_wdata_o,
    input  logic [31:0]       mem_rdata_i,
    input  logic              mem_ack_i,
    output logic              arb_point_o,
    output logic              done_o,
    output logic              err_o,
    output logic              wb_valid_o,
    output logic [31:0]       wb_ctrl_o,
    output logic              wb_alt_o
);
    localparam int SIDES = 2;

    typedef struct packed {
        eng_st_e           st;
        ctl_word_t         ctl;
        logic [ADDR_W-1:0] s_end;
        logic [ADDR_W-1:0] d_end;
        logic [CNT_W-1:0]  rem;
        logic [CNT_W-1:0]  beat;
        logic [DATA_W-1:0] item;
        logic              alt;
    } eng_reg_t;

    eng_reg_t r_q, r_d;

    logic             self_req, swap;
    logic [CNT_W-1:0] span_m1;
    ctl_word_t        in_ctl;
    ctl_word_t        wb_word;

    logic [ADDR_W-1:0] side_end  [SIDES];
    logic [1:0]        side_inc  [SIDES];
    logic [ADDR_W-1:0] side_addr [SIDES];

    logic [DATA_W-1:0] rd_item, wr_data;
    logic [BE_W-1:0]   rd_be, wr_be;

    assign in_ctl = ctl_word_t'(desc_ctrl_i);

    dmaeng_ctl_dec u_dec (
        .rpow_i     (r_q.ctl.rpow),
        .cyc_i      (r_q.ctl.cyc),
        .self_req_o (self_req),
        .swap_o     (swap),
        .span_m1_o  (span_m1)
    );

    assign side_end[0] = r_q.s_end;
    assign side_end[1] = r_q.d_end;
    assign side_inc[0] = r_q.ctl.sinc;
    assign side_inc[1] = r_q.ctl.dinc;

    for (genvar g = 0; g < SIDES; g++) begin : g_agen
        dmaeng_agen #(
            .ADDR_W (ADDR_W),
            .CNT_W  (CNT_W)
        ) u_agen (
            .end_ptr_i (side_end[g]),
            .remain_i  (r_q.rem),
            .inc_i     (side_inc[g]),
            .addr_o    (side_addr[g])
        );
    end

    dmaeng_lane u_lane (
        .rd_lo_i   (side_addr[0][1:0]),
        .rd_sz_i   (r_q.ctl.ssz),
        .rdata_i   (mem_rdata_i),
        .rd_item_o (rd_item),
        .rd_be_o   (rd_be),
        .wr_lo_i   (side_addr[1][1:0]),
        .wr_sz_i   (r_q.ctl.dsz),
        .item_i    (r_q.item),
        .wdata_o   (wr_data),
        .wr_be_o   (wr_be)
    );

    // Next-state computation
    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (chan_en_i && req_i && desc_valid_i) begin
                    r_d.ctl   = in_ctl;
                    r_d.s_end = desc_src_end_i;
                    r_d.d_end = desc_dst_end_i;
                    r_d.rem   = in_ctl.nm1;
                    r_d.beat  = '0;
                    r_d.st    = mode_runs(in_ctl.cyc) ? ST_RD : ST_FAULT;
                end
            end
            ST_RD: begin
                if (mem_ack_i) begin
                    r_d.item = rd_item;
                    r_d.st   = ST_WR;
                end
            end
            ST_WR: begin
                if (mem_ack_i) begin
                    if (r_q.rem == '0) begin
                        r_d.st = ST_FIN;
                    end else begin
                        r_d.rem = r_q.rem - 1'b1;
                        if (r_q.beat == span_m1) begin
                            r_d.beat = '0;
                            r_d.st   = ST_PARK;
                        end else begin
                            r_d.beat = r_q.beat + 1'b1;
                            r_d.st   = ST_RD;
                        end
                    end
                end
            end
            ST_PARK: begin
                if (self_req || req_i) begin
                    r_d.st = ST_RD;
                end
            end
            ST_FIN: begin
                if (swap) begin
                    r_d.alt = ~r_q.alt;
                end
                r_d.st = ST_IDLE;
            end
            ST_FAULT: begin
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // Outputs
    always_comb begin
        wb_word     = r_q.ctl;
        wb_word.nm1 = '0;
        wb_word.cyc = CY_STOP;
    end

    assign desc_ready_o = (r_q.st == ST_IDLE) && chan_en_i && req_i && desc_valid_i;
    assign mem_req_o    = (r_q.st == ST_RD) || (r_q.st == ST_WR);
    assign mem_we_o     = (r_q.st == ST_WR);
    assign mem_addr_o   = (r_q.st == ST_WR) ? side_addr[1] : side_addr[0];
    assign mem_be_o     = (r_q.st == ST_WR) ? wr_be : rd_be;
    assign mem_wdata_o  = wr_data;
    assign arb_point_o  = (r_q.st == ST_PARK);
    assign done_o       = (r_q.st == ST_FIN);
    assign wb_valid_o   = (r_q.st == ST_FIN);
    assign wb_ctrl_o    = wb_word;
    assign wb_alt_o     = r_q.alt;
    assign alt_sel_o    = r_q.alt;
    assign err_o        = (r_q.st == ST_FAULT);

endmodule

// File: rtl/dmaeng_chk.sv
module dmaeng_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req_o,
    input logic              mem_ack_i,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              err_o,
    input logic              done_o,
    input logic              arb_point_o,
    input logic              alt_sel_o,
    input logic              desc_ready_o
);
    // R12
    fault_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !mem_req_o);

    // R7
    park_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arb_point_o |-> !mem_req_o);

    // R10
    done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!mem_req_o && !done_o));

    // R11
    alt_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(alt_sel_o) |-> $past(done_o));

    // R13
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

    // R2
    intake_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_ready_o |-> !mem_req_o);

    // R12
    fault_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_o && done_o));

endmodule

bind dma_chan_engine dmaeng_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_req_o    (mem_req_o),
    .mem_ack_i    (mem_ack_i),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .err_o        (err_o),
    .done_o       (done_o),
    .arb_point_o  (arb_point_o),
    .alt_sel_o    (alt_sel_o),
    .desc_ready_o (desc_ready_o)
);

// File: tb/sim_dma_chan_engine.sv
`timescale 1ns/1ps
module sim_dma_chan_engine;

    localparam int AW = 32;
    localparam real HALF = 4.0;
    localparam logic [31:0] WB_KEEP = ~32'h0000_3FF7;

    function automatic logic [31:0] mk(input logic [1:0] di, input logic [1:0] ds,
                                       input logic [1:0] si, input logic [1:0] ss,
                                       input logic [3:0] r, input logic [9:0] nm1,
                                       input logic [2:0] cy);
        return {di, ds, si, ss, 3'b101, 3'b010, r, nm1, 1'b0, cy};
    endfunction

    // {ctrl, src_end, dst_end, expected parks, expected writes}
    localparam logic [127:0] VEC [5] = '{
        {mk(2'b10, 2'b10, 2'b10, 2'b10, 4'd0, 10'd3, 3'b010), 32'h0000_000C, 32'h0000_020C, 16'd3, 16'd4},
        {mk(2'b00, 2'b00, 2'b00, 2'b00, 4'd1, 10'd5, 3'b010), 32'h0000_0045, 32'h0000_0243, 16'd2, 16'd6},
        {mk(2'b01, 2'b01, 2'b01, 2'b01, 4'd1, 10'd3, 3'b001), 32'h0000_0086, 32'h0000_028A, 16'd1, 16'd4},
        {mk(2'b11, 2'b10, 2'b10, 2'b10, 4'd3, 10'd2, 3'b010), 32'h0000_00C8, 32'h0000_02F0, 16'd0, 16'd3},
        {mk(2'b10, 2'b10, 2'b00, 2'b00, 4'd2, 10'd2, 3'b010), 32'h0000_00D2, 32'h0000_0308, 16'd0, 16'd3}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chan_en = 1'b0, req = 1'b0, desc_valid = 1'b0;
    logic [AW-1:0] src_end = '0, dst_end = '0;
    logic [31:0] ctrl = '0;
    logic desc_ready, alt_sel, mem_req, mem_we, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [3:0] mem_be;
    logic [31:0] mem_wdata, mem_rdata;
    logic arb_point, done, err, wb_valid, wb_alt;
    logic [31:0] wb_ctrl;

    logic stall = 1'b0;
    logic init_req = 1'b0;
    logic clr = 1'b0;
    logic [31:0] mem  [256];
    logic [31:0] refm [256];
    int wr_cnt = 0, rq_cnt = 0, yld_cnt = 0, done_cnt = 0;
    logic arb_prev = 1'b0;

    int checks = 0;
    int fails = 0;

    always #(HALF) clk = ~clk;

    dma_chan_engine #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .chan_en_i(chan_en), .req_i(req),
        .desc_valid_i(desc_valid), .desc_ready_o(desc_ready),
        .desc_src_end_i(src_end), .desc_dst_end_i(dst_end), .desc_ctrl_i(ctrl),
        .alt_sel_o(alt_sel), .mem_req_o(mem_req), .mem_we_o(mem_we),
        .mem_addr_o(mem_addr), .mem_be_o(mem_be), .mem_wdata_o(mem_wdata),
        .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack), .arb_point_o(arb_point),
        .done_o(done), .err_o(err), .wb_valid_o(wb_valid), .wb_ctrl_o(wb_ctrl),
        .wb_alt_o(wb_alt)
    );

    // Memory model and event counters
    assign mem_ack   = mem_req && !stall;
    assign mem_rdata = mem[mem_addr[9:2]];

    always @(posedge clk) begin
        if (init_req) begin
            for (int w = 0; w < 256; w++) mem[w] <= 32'hA500_0000 ^ (32'(w) * 32'h0103_0507);
        end else if (mem_req && mem_ack && mem_we) begin
            for (int b = 0; b < 4; b++)
                if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
        end
        if (clr) begin
            wr_cnt <= 0; rq_cnt <= 0; yld_cnt <= 0; done_cnt <= 0;
        end else begin
            if (mem_req && mem_ack && mem_we) wr_cnt <= wr_cnt + 1;
            if (mem_req) rq_cnt <= rq_cnt + 1;
            if (arb_point && !arb_prev) yld_cnt <= yld_cnt + 1;
            if (done) done_cnt <= done_cnt + 1;
        end
        arb_prev <= arb_point;
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [31:0] item_addr(input logic [31:0] e, input int n,
                                              input int i, input logic [1:0] inc);
        if (inc == 2'b11) return e;
        return e - (32'(n - 1 - i) << inc);
    endfunction

    // Requirement-level reference: item i read then written, in order
    task automatic ref_run(input logic [31:0] c, input logic [31:0] se, input logic [31:0] de);
        int n;
        logic [31:0] sa, da, v, wd;
        logic [3:0] be;
        n = int'(c[13:4]) + 1;
        for (int i = 0; i < n; i++) begin
            sa = item_addr(se, n, i, c[27:26]);
            da = item_addr(de, n, i, c[31:30]);
            v = refm[sa[9:2]];
            case (c[25:24])
                2'b00:   v = (v >> (8 * sa[1:0])) & 32'hFF;
                2'b01:   v = (v >> (16 * sa[1])) & 32'hFFFF;
                default: v = v;
            endcase
            case (c[29:28])
                2'b00:   begin wd = {4{v[7:0]}};  be = 4'b0001 << da[1:0]; end
                2'b01:   begin wd = {2{v[15:0]}}; be = da[1] ? 4'b1100 : 4'b0011; end
                default: begin wd = v;            be = 4'b1111; end
            endcase
            for (int b = 0; b < 4; b++)
                if (be[b]) refm[da[9:2]][8*b +: 8] = wd[8*b +: 8];
        end
    endtask

    task automatic start(input logic [31:0] c, input logic [31:0] se, input logic [31:0] de,
                         input bit keep_req);
        @(negedge clk);
        clr = 1'b1;
        for (int w = 0; w < 256; w++) refm[w] = mem[w];
        @(negedge clk);
        clr = 1'b0;
        ctrl = c; src_end = se; dst_end = de;
        chan_en = 1'b1; req = 1'b1; desc_valid = 1'b1;
        #1;
        chk(desc_ready === 1'b1, "R2", "ready on full handshake", desc_ready, 1);
        @(negedge clk);
        desc_valid = 1'b0;
        if (!keep_req) req = 1'b0;
    endtask

    task automatic wait_end(output bit d, output bit e, output logic [31:0] wc, output bit wa);
        for (int i = 0; i < 6000; i++) begin
            if (done || err) break;
            @(negedge clk);
        end
        d = done; e = err; wc = wb_ctrl; wa = wb_alt;
    endtask

    task automatic mem_cmp(input string rq);
        int bad = 0;
        int first = -1;
        for (int w = 0; w < 256; w++)
            if (mem[w] !== refm[w]) begin
                bad++;
                if (first < 0) first = w;
            end
        if (first < 0) first = 0;
        chk(bad == 0, rq, "memory image", mem[first], refm[first]);
    endtask

    initial begin
        #(2.0 * HALF * 190000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        bit d, e, wa;
        logic [31:0] wc, c;

        init_req = 1'b1;
        repeat (3) @(negedge clk);
        chk(!mem_req && !done && !err && !wb_valid && !arb_point && !alt_sel,
            "R1", "outputs in reset", {mem_req, done, err, wb_valid, arb_point, alt_sel}, 0);
        rst_n = 1'b1;
        init_req = 1'b0;
        @(negedge clk);
        chk(!mem_req && !done && !err && !wb_valid && !arb_point && !alt_sel,
            "R1", "outputs after reset", {mem_req, done, err, wb_valid, arb_point, alt_sel}, 0);

        // R2: disabled channel takes nothing
        clr = 1'b1; @(negedge clk); clr = 1'b0;
        ctrl = VEC[0][127:96]; src_end = VEC[0][95:64]; dst_end = VEC[0][63:32];
        chan_en = 1'b0; req = 1'b1; desc_valid = 1'b1;
        repeat (5) begin
            #1;
            chk(desc_ready === 1'b0, "R2", "ready with channel off", desc_ready, 0);
            @(negedge clk);
        end
        desc_valid = 1'b0; req = 1'b0;
        chk(rq_cnt == 0, "R2", "bus requests with channel off", rq_cnt, 0);

        // Table walk: R3 R4 R5 R6 R7 R8 R10
        for (int k = 0; k < 5; k++) begin
            c = VEC[k][127:96];
            start(c, VEC[k][95:64], VEC[k][63:32], c[2:0] == 3'b001);
            ref_run(c, VEC[k][95:64], VEC[k][63:32]);
            wait_end(d, e, wc, wa);
            chk(d && !e, "R10", "done seen", {d, e}, 2'b10);
            chk(wc == (c & WB_KEEP), "R10", "write-back word", wc, c & WB_KEEP);
            @(negedge clk);
            chk(!done && !wb_valid, "R10", "done one cycle", {done, wb_valid}, 0);
            req = 1'b0;
            mem_cmp("R4 R5 R6 R3");
            chk(wr_cnt == int'(VEC[k][15:0]), "R4", "write count", wr_cnt, VEC[k][15:0]);
            chk(yld_cnt == int'(VEC[k][31:16]), "R7 R8", "park count", yld_cnt, VEC[k][31:16]);
            chk(alt_sel == 1'b0, "R11", "select untouched by non-pingpong", alt_sel, 0);
        end

        // R12: stop and gather codes
        for (int k = 0; k < 2; k++) begin
            c = mk(2'b10, 2'b10, 2'b10, 2'b10, 4'd0, 10'd3, (k == 0) ? 3'b000 : 3'b101);
            start(c, 32'h10, 32'h310, 1'b0);
            wait_end(d, e, wc, wa);
            chk(e && !d, "R12", "error pulse", {d, e}, 2'b01);
            @(negedge clk);
            chk(rq_cnt == 0 && done_cnt == 0 && !err, "R12", "no access or done",
                {rq_cnt[15:0], done_cnt[15:0], err}, 0);
        end

        // R9: basic parks until request returns
        c = mk(2'b10, 2'b10, 2'b10, 2'b10, 4'd1, 10'd3, 3'b001);
        start(c, 32'h1C, 32'h31C, 1'b0);
        ref_run(c, 32'h1C, 32'h31C);
        repeat (30) @(negedge clk);
        chk(arb_point === 1'b1 && wr_cnt == 2, "R9", "parked without request",
            {arb_point, wr_cnt[15:0]}, {1'b1, 16'd2});
        req = 1'b1;
        wait_end(d, e, wc, wa);
        chk(d, "R9", "finishes after request", d, 1);
        @(negedge clk);
        req = 1'b0;
        mem_cmp("R9");

        // R11: ping-pong toggles primary/alternate
        for (int k = 0; k < 2; k++) begin
            c = mk(2'b10, 2'b10, 2'b10, 2'b10, 4'd3, 10'd1, 3'b011);
            start(c, 32'h24, 32'h324, 1'b1);
            wait_end(d, e, wc, wa);
            chk(d && wa == 1'(k), "R11", "write-back names descriptor", {d, wa}, {1'b1, 1'(k)});
            @(negedge clk);
            chk(alt_sel == 1'(1 - k), "R11", "select flipped", alt_sel, 1 - k);
            req = 1'b0;
        end

        // R7: large power codes
        for (int k = 0; k < 3; k++) begin
            logic [3:0] rp;
            rp = (k == 0) ? 4'd10 : (k == 1) ? 4'd15 : 4'd9;
            c = mk(2'b11, 2'b10, 2'b11, 2'b10, rp, 10'd1023, 3'b010);
            start(c, 32'hF0, 32'h3F0, 1'b0);
            wait_end(d, e, wc, wa);
            chk(d && wr_cnt == 1024, "R4", "1024 items", wr_cnt, 1024);
            chk(yld_cnt == ((k == 2) ? 1 : 0), "R7", "park count for large R",
                yld_cnt, (k == 2) ? 1 : 0);
            @(negedge clk);
        end

        // R13: request held through a stalled bus
        stall = 1'b1;
        c = mk(2'b10, 2'b10, 2'b10, 2'b10, 4'd0, 10'd1, 3'b010);
        start(c, 32'h04, 32'h344, 1'b0);
        ref_run(c, 32'h04, 32'h344);
        repeat (10) @(negedge clk);
        chk(mem_req && !mem_we && mem_addr == 32'h0 && wr_cnt == 0, "R13", "stalled read held",
            {mem_req, mem_we, mem_addr}, {1'b1, 1'b0, 32'h0});
        stall = 1'b0;
        wait_end(d, e, wc, wa);
        chk(d, "R13", "completes after stall", d, 1);
        @(negedge clk);
        mem_cmp("R13");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule